// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the master of a single shared interrupt line that is pulled low by any agent and otherwise floats high. Devices report the levels of their interrupt and data lines by pulling the wire low in their own time slot, and the host turns that slot train back into a parallel vector of levels. The open-drain pin appears as three signals: a drive enable, a drive value, and the sampled line level.

A transfer opens with a low Start pulse. The host issues it itself, or, in quiet mode, a device starts it by pulling the idle line low for one clock and the host then stretches it. The host then counts 3-clock slots, samples the line once per slot, and closes the transfer with a low Stop pulse. A 2-clock Stop means the next transfer runs in quiet mode, where devices may open transfers. A 3-clock Stop means continuous mode, where only the host may open them. A 6-bit setting holds the Start width in bits [1:0] and the slot count in bits [5:2]. The host copies the setting at each Start.

Top module: `sirq_host`

## Requirements
- R1: The Start low time follows setting bits [1:0]: 00 gives 4 clocks, 01 gives 6 clocks, and 10 or 11 gives 8 clocks.
- R2: In quiet mode, a single low clock on the idle line opens a transfer. The host drives low from the next clock, so the whole Start low time, including the device's clock, equals the R1 width.
- R3: After each low pulse (Start or Stop) the host drives the line high for exactly one clock and then releases it for at least one clock.
- R4: Taking the Start high clock as clock 0, slot N (1-based) is sampled at the end of clock 3N-1. Bit N-1 of `irqLevels` takes the sampled line level at that edge and not before.
- R5: The number of slots is 17 plus setting bits [5:2] (17 to 32). The Stop low time begins at clock 3F+2, where F is the slot count.
- R6: When a transfer starts, every `irqLevels` bit at a position at or above its slot count reads 1.
- R7: The Stop is 2 low clocks when `quietReq` is 1 and 3 low clocks when it is 0, sampled when the last slot ends. `quietMode` takes that value after the Stop high clock.
- R8: During reset the line is released, `irqLevels` is all ones and the mode is continuous. After reset the host opens the first transfer by itself, using 4-clock Start and 17 slots.
- R9: In continuous mode a low idle line opens no transfer, and `hostKick` does open one.
- R10: `hostKick` pulses seen during a transfer are dropped. No transfer follows unless a new request arrives while the line is idle.
- R11: A change of `quietReq` during a transfer leaves `quietMode` unchanged until the Stop pulse of that transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Setting register write strobe |
| cfgWrData | input | 6 | Setting: [1:0] Start width, [5:2] slot count minus 17 |
| hostKick | input | 1 | Host request to open a transfer |
| quietReq | input | 1 | Mode requested for the next transfer (1 = quiet) |
| serIn | input | 1 | Sampled level of the shared line |
| serOe | output | 1 | Host drives the line |
| serOut | output | 1 | Level driven when serOe is 1 |
| irqLevels | output | 32 | Recovered per-slot levels |
| cycleActive | output | 1 | A transfer is in progress |
| quietMode | output | 1 | Current mode (1 = quiet) |

## Verification
The bench builds the block with its default parameters: 32 level slots, 17 minimum slots and a 4-bit count field. With these values every slot count from 17 to 32 can be set, and all four Start width codes can be used. Its vector table uses both host-opened and device-opened transfers and switches between quiet and continuous mode. It goes from a 32-slot transfer to shorter ones, so the masking of upper slots to 1 can be observed.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLO, ST_SHI, ST_STA, ST_FRM, ST_PLO, ST_PHI, ST_PTA
  } ctlStateT;

  typedef enum logic [1:0] {
    LK_HOST, LK_SLAVE, LK_STOP2, LK_STOP3
  } lowKindT;

  typedef struct packed {
    logic    latchCfg;
    logic    loadLow;
    lowKindT lowKind;
    logic    tickLow;
    logic    clrFrame;
    logic    stepFrame;
    logic    sampleNow;
  } strobeT;

  typedef struct packed {
    logic lowLast;
    logic isSample;
    logic frameLast;
  } statusT;

  function automatic logic [3:0] startWidth(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int MIN_FRAMES = 17,
  parameter int SEL_W      = 4,
  localparam int CFG_W     = SEL_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  input  strobeT               strb,
  input  logic                 serIn,
  output statusT               stat,
  output logic [NUM_SLOTS-1:0] irqLevels
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int TOT_W = IDX_W + 1;

  logic [1:0]       widthReg;
  logic [SEL_W-1:0] framesReg;
  logic [SEL_W-1:0] framesSnap;
  logic [3:0]       lowCnt;
  logic [3:0]       lowLoad;
  logic [IDX_W-1:0] frameIdx;
  logic [1:0]       phase;
  logic [TOT_W-1:0] frameTotal;
  logic [TOT_W-1:0] nextTotal;

  assign frameTotal = TOT_W'(MIN_FRAMES) + TOT_W'(framesSnap);
  assign nextTotal  = TOT_W'(MIN_FRAMES) + TOT_W'(framesReg);

  always_comb begin
    case (strb.lowKind)
      LK_HOST:  lowLoad = startWidth(widthReg);
      LK_SLAVE: lowLoad = startWidth(widthReg) - 4'd1;
      LK_STOP2: lowLoad = 4'd2;
      default:  lowLoad = 4'd3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthReg   <= '0;
      framesReg  <= '0;
      framesSnap <= '0;
      lowCnt     <= '0;
      frameIdx   <= '0;
      phase      <= '0;
    end else begin
      if (cfgWrEn) {framesReg, widthReg} <= cfgWrData;
      if (strb.latchCfg) framesSnap <= framesReg;
      if (strb.loadLow) lowCnt <= lowLoad;
      else if (strb.tickLow) lowCnt <= lowCnt - 4'd1;
      if (strb.clrFrame) begin
        frameIdx <= '0;
        phase    <= '0;
      end else if (strb.stepFrame) begin
        if (phase == 2'd2) begin
          phase    <= '0;
          frameIdx <= frameIdx + IDX_W'(1);
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  // One register per slot; slots past the new count are forced high at Start
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [TOT_W-1:0] POS = TOT_W'(i);
    always_ff @(posedge clk) begin
      if (!rstN) irqLevels[i] <= 1'b1;
      else if (strb.latchCfg && (POS >= nextTotal)) irqLevels[i] <= 1'b1;
      else if (strb.sampleNow && (frameIdx == IDX_W'(i))) irqLevels[i] <= serIn;
    end
  end

  assign stat.lowLast   = (lowCnt == 4'd1);
  assign stat.isSample  = (phase == 2'd0);
  assign stat.frameLast = (phase == 2'd2) && ({1'b0, frameIdx} == frameTotal - TOT_W'(1));

endmodule

// File: rtl/sirq_control.sv
module sirq_control
  import sirq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   hostKick,
  input  logic   quietReq,
  input  logic   serIn,
  input  statusT stat,
  output strobeT strb,
  output logic   serOe,
  output logic   serOut,
  output logic   cycleActive,
  output logic   quietMode
);
  ctlStateT state, nextState;
  logic curQuiet;
  logic stopQuiet;
  logic firstPend;

  always_comb begin
    strb         = '0;
    strb.lowKind = LK_HOST;
    nextState    = state;
    serOe        = 1'b0;
    serOut       = 1'b1;
    case (state)
      ST_IDLE: begin
        if (curQuiet && !serIn) begin
          strb.latchCfg = 1'b1;
          strb.loadLow  = 1'b1;
          strb.lowKind  = LK_SLAVE;
          nextState     = ST_SLO;
        end else if (firstPend || hostKick) begin
          strb.latchCfg = 1'b1;
          strb.loadLow  = 1'b1;
          strb.lowKind  = LK_HOST;
          nextState     = ST_SLO;
        end
      end
      ST_SLO: begin
        serOe        = 1'b1;
        serOut       = 1'b0;
        strb.tickLow = 1'b1;
        if (stat.lowLast) nextState = ST_SHI;
      end
      ST_SHI: begin
        serOe         = 1'b1;
        strb.clrFrame = 1'b1;
        nextState     = ST_STA;
      end
      ST_STA: nextState = ST_FRM;
      ST_FRM: begin
        strb.stepFrame = 1'b1;
        strb.sampleNow = stat.isSample;
        if (stat.frameLast) begin
          strb.loadLow = 1'b1;
          strb.lowKind = quietReq ? LK_STOP2 : LK_STOP3;
          nextState    = ST_PLO;
        end
      end
      ST_PLO: begin
        serOe        = 1'b1;
        serOut       = 1'b0;
        strb.tickLow = 1'b1;
        if (stat.lowLast) nextState = ST_PHI;
      end
      ST_PHI: begin
        serOe     = 1'b1;
        nextState = ST_PTA;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curQuiet  <= 1'b0;
      stopQuiet <= 1'b0;
      firstPend <= 1'b1;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && nextState == ST_SLO) firstPend <= 1'b0;
      if (state == ST_FRM && stat.frameLast) stopQuiet <= quietReq;
      if (state == ST_PHI) curQuiet <= stopQuiet;
    end
  end

  assign cycleActive = (state != ST_IDLE);
  assign quietMode   = curQuiet;

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int MIN_FRAMES = 17,
  parameter int SEL_W      = 4,
  localparam int CFG_W     = SEL_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  input  logic                 hostKick,
  input  logic                 quietReq,
  input  logic                 serIn,
  output logic                 serOe,
  output logic                 serOut,
  output logic [NUM_SLOTS-1:0] irqLevels,
  output logic                 cycleActive,
  output logic                 quietMode
);
  strobeT strb;
  statusT stat;

  sirq_control ctl_i (
    .clk(clk), .rstN(rstN), .hostKick(hostKick), .quietReq(quietReq),
    .serIn(serIn), .stat(stat), .strb(strb), .serOe(serOe), .serOut(serOut),
    .cycleActive(cycleActive), .quietMode(quietMode)
  );

  sirq_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .MIN_FRAMES(MIN_FRAMES), .SEL_W(SEL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .strb(strb), .serIn(serIn), .stat(stat), .irqLevels(irqLevels)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 serOe,
  input logic                 serOut,
  input logic                 cycleActive,
  input logic                 quietMode,
  input logic [NUM_SLOTS-1:0] irqLevels
);
  logic [4:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else if (serOe && !serOut) lowRun <= (lowRun == 5'd31) ? lowRun : lowRun + 5'd1;
    else lowRun <= '0;
  end

  p_low_bounded_r1: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= 5'd8);

  p_low_then_driven_r3: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && !serOut) |=> serOe);

  p_release_after_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && serOut) |=> !serOe);

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cycleActive |-> !serOe);

  p_levels_when_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqLevels) |-> $past(!serOe));

  p_mode_at_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(quietMode) |-> $past(serOe && serOut));

endmodule

bind sirq_host sirq_host_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rstN(rstN), .serOe(serOe), .serOut(serOut),
  .cycleActive(cycleActive), .quietMode(quietMode), .irqLevels(irqLevels)
);

// File: tb/sirq_host_tb_top.sv
module sirq_host_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgWrData = '0;
  logic        hostKick = 1'b0;
  logic        quietReq = 1'b0;
  logic        slavePull = 1'b0;
  logic        serIn;
  logic        serOe, serOut, cycleActive, quietMode;
  logic [31:0] irqLevels;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign serIn = !((serOe && !serOut) || slavePull);

  sirq_host dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hostKick(hostKick), .quietReq(quietReq), .serIn(serIn), .serOe(serOe),
    .serOut(serOut), .irqLevels(irqLevels), .cycleActive(cycleActive),
    .quietMode(quietMode)
  );

  typedef struct packed {
    logic [1:0]  wSel;
    logic [3:0]  fSel;
    logic        quiet;
    logic [31:0] pat;
    logic [3:0]  expW;
    logic [5:0]  expF;
  } vecT;

  localparam vecT VECS [5] = '{
    '{2'b00, 4'd0,  1'b1, 32'hFFFF_5A3D, 4'd4, 6'd17},
    '{2'b01, 4'd1,  1'b0, 32'h0001_2344, 4'd6, 6'd18},
    '{2'b10, 4'd15, 1'b1, 32'h1234_ABCD, 4'd8, 6'd32},
    '{2'b11, 4'd3,  1'b1, 32'hC0F0_EE10, 4'd8, 6'd20},
    '{2'b00, 4'd0,  1'b0, 32'h0F0F_0F0F, 4'd4, 6'd17}
  };

  int   rStartLow, rStopAt, rStopLow, rHiAt;
  logic rRelOk, rStartRel, rBit0Pre, rBit0Post, rModeMid;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expLv(input logic [31:0] pat, input int frames);
    logic [31:0] r;
    r = pat;
    for (int b = 0; b < 32; b++) if (b >= frames) r[b] = 1'b1;
    return r;
  endfunction

  task automatic serve(input logic [31:0] pat, input int frames, input logic viaSlave,
                       input logic viaHost, input int kickAt, input int flipAt);
    int run;
    run = 0; rStopAt = 0; rStopLow = 0; rHiAt = 0;
    rRelOk = 1'b0; rStartRel = 1'b0; rModeMid = quietMode;
    @(negedge clk);
    slavePull = viaSlave;
    hostKick  = viaHost;
    #1;
    if (!serIn) run = 1;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      slavePull = 1'b0;
      hostKick  = 1'b0;
      #1;
      if (serOe && serOut) break;
      if (!serIn) run++;
      else run = 0;
    end
    rStartLow = run;
    for (int k = 1; k <= 3 * frames + 7; k++) begin
      @(negedge clk);
      slavePull = (k % 3 == 2) && (k / 3 < frames) && !pat[k / 3];
      hostKick  = (k == kickAt);
      if (k == flipAt) quietReq = !quietReq;
      #1;
      if (k == 1) rStartRel = !serOe;
      if (k == 2) rBit0Pre = irqLevels[0];
      if (k == 3) rBit0Post = irqLevels[0];
      if (k == frames) rModeMid = quietMode;
      if (serOe && !serOut) begin
        if (rStopAt == 0) rStopAt = k;
        rStopLow++;
      end
      if (rStopAt != 0 && serOe && serOut) rHiAt = k;
      if (rHiAt != 0 && k == rHiAt + 1) rRelOk = !serOe;
    end
    slavePull = 1'b0;
    hostKick  = 1'b0;
  endtask

  task automatic writeCfg(input logic [1:0] w, input logic [3:0] f);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = {f, w};
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic        modeQ;
    logic [31:0] prevLv;
    logic [31:0] p0;

    // R8: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R8 serOe in reset", int'(serOe), 0);
    chk32("R8 levels in reset", irqLevels, 32'hFFFF_FFFF);
    chk("R8 mode in reset", int'(quietMode), 0);
    chk("R8 active in reset", int'(cycleActive), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R8: host-opened first cycle with default setting
    p0 = 32'hFFFE_FFFE;
    serve(p0, 17, 1'b0, 1'b0, 0, 0);
    chk("R8 R1 first start width", rStartLow, 4);
    chk("R5 first stop position", rStopAt, 3 * 17 + 2);
    chk("R7 first stop width", rStopLow, 3);
    chk32("R4 first levels", irqLevels, expLv(p0, 17));
    prevLv = expLv(p0, 17);
    modeQ  = 1'b0;

    for (int i = 0; i < 5; i++) begin
      writeCfg(VECS[i].wSel, VECS[i].fSel);
      quietReq = VECS[i].quiet;
      serve(VECS[i].pat, int'(VECS[i].expF), modeQ, !modeQ, 0, 0);
      chk(modeQ ? "R2 slave start width" : "R1 host start width", rStartLow, int'(VECS[i].expW));
      chk("R3 release after start high", int'(rStartRel), 1);
      chk("R4 slot1 before sample edge", int'(rBit0Pre), int'(prevLv[0]));
      chk("R4 slot1 after sample edge", int'(rBit0Post), int'(VECS[i].pat[0]));
      chk("R5 stop position", rStopAt, 3 * int'(VECS[i].expF) + 2);
      chk("R7 stop width", rStopLow, VECS[i].quiet ? 2 : 3);
      chk("R3 stop high single clock", rHiAt, rStopAt + rStopLow);
      chk("R3 release after stop high", int'(rRelOk), 1);
      chk32("R4 R6 levels", irqLevels, expLv(VECS[i].pat, int'(VECS[i].expF)));
      chk("R7 mode after stop", int'(quietMode), int'(VECS[i].quiet));
      prevLv = expLv(VECS[i].pat, int'(VECS[i].expF));
      modeQ  = VECS[i].quiet;
    end

    // R9: continuous mode, device pull on idle line is ignored
    @(negedge clk);
    slavePull = 1'b1;
    @(negedge clk);
    slavePull = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 no start from device", int'(cycleActive), 0);
    chk("R9 line released", int'(serOe), 0);

    // R10 R11: host cycle with mid-cycle kick and mode flip
    writeCfg(2'b00, 4'd0);
    quietReq = 1'b1;
    serve(32'hAAAA_AAAA, 17, 1'b0, 1'b1, 10, 12);
    chk("R9 host kick opens cycle", rStartLow, 4);
    chk("R11 mode held mid-cycle", int'(rModeMid), 0);
    chk("R7 R11 stop uses value at last slot", rStopLow, 3);
    chk("R11 mode after stop", int'(quietMode), 0);
    repeat (4) @(negedge clk);
    #1;
    chk("R10 mid-cycle kick dropped", int'(cycleActive), 0);

    // R8: reset again mid-cycle, then automatic first cycle
    quietReq = 1'b0;
    @(negedge clk);
    hostKick = 1'b1;
    @(negedge clk);
    hostKick = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    #1;
    chk("R8 released in reset", int'(serOe), 0);
    chk32("R8 levels cleared", irqLevels, 32'hFFFF_FFFF);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 auto cycle after reset", int'(cycleActive), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule